// File: doc/BRIEF.md
# Cascadable Interval Timer with Buffered Compare

This block is an up-counting timer built from two equal halves. Each half has a data register that software writes and a hidden compare latch that is filled from that register. A half counts either a common internal tick strobe (interval mode) or the rising edges of its own asynchronous event input (event mode). When the count equals the compare latch, the next count step returns the count to zero, refills the latch from the data register and raises a sticky match flag. The period is therefore the programmed value plus one count steps.

Reading a half gives its live count and never the value that was written, so software cannot read back the compare setting. A new value written while the half runs waits in the data register and takes effect at the next match or at the next start.

With the cascade input set, the two halves form one double-width counter with a double-width compare. The upper data register supplies the upper part of the compare value. Only the lower channel's run control, source select, event input and flag take part in this mode.

Top module: `cascade_timer`

## Requirements
- R1: `rd_data` shows the live count of the half picked by `rd_sel` (0 lower, 1 upper); a write to the data register never appears on `rd_data`.
- R2: A 0-to-1 change on `run[i]` clears that half's count to zero and loads its compare latch from its data register, before any count step is taken.
- R3: While `run[i]` is 0, that half's count holds its value whatever happens on `tick_i` and `evt_i`.
- R4: In interval mode (`src_sel[i]`=0), each cycle with `tick_i` high while running is one count step; a step taken while count equals the latch sets the count to zero, reloads the latch and sets the flag, so a programmed value V gives a period of V+1 steps.
- R5: A data-register write while a half runs does not change the current period; the new value is used only after the next match.
- R6: In event mode (`src_sel[i]`=1), `evt_i[i]` passes through a two-flop synchronizer, one step is taken per rising edge, and `tick_i` has no effect on that half.
- R7: `flag_o[i]` stays set until a cycle with `flag_clr[i]` high clears it; a new match in the same cycle keeps it set.
- R8: With `cascade`=1 the count is {upper, lower} and the compare is {upper data, lower data}; `run[0]`, `src_sel[0]`, `evt_i[0]` govern it, the match sets `flag_o[0]`, and `flag_o[1]` is never set.
- R9: With `cascade`=0 the two halves count, match and flag independently of each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Data-register write strobe |
| wr_sel | input | 1 | Half written: 0 lower, 1 upper |
| wr_data | input | HALF_W | Compare value to store |
| rd_sel | input | 1 | Half read: 0 lower, 1 upper |
| rd_data | output | HALF_W | Live count of the selected half |
| run | input | 2 | Run level per half; rising edge starts |
| cascade | input | 1 | 1 joins both halves into one wide timer |
| src_sel | input | 2 | Count source per half: 0 tick, 1 event |
| tick_i | input | 1 | Internal count tick strobe |
| evt_i | input | 2 | Asynchronous event input per half |
| flag_clr | input | 2 | Clears the match flag of a half |
| flag_o | output | 2 | Sticky match flag per half |

## Verification
The bench builds the block with its default parameters, 8-bit halves and two synchronizer stages. At that width every interval period, including the full 256-step wrap of one half, fits in a short run. So does a 16-bit cascaded compare of 300 steps, which crosses the lower-half carry into the upper half before it matches. The two-stage synchronizer keeps the event-to-count delay short, so the event counts can be checked a few cycles after each pulse.

// File: rtl/cascade_timer_pkg.sv
package cascade_timer_pkg;
  typedef enum logic {
    SRC_TICK  = 1'b0,
    SRC_EVENT = 1'b1
  } src_e;
endpackage

// File: rtl/ct_event_sync.sv
module ct_event_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic evt_i,
  output logic rise_o
);
  localparam int DEPTH = STAGES + 1;

  logic [DEPTH-1:0] sync_q;
  logic [DEPTH-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[DEPTH-2:0], evt_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rise_o = sync_q[STAGES-1] & ~sync_q[STAGES];
endmodule

// File: rtl/ct_half.sv
module ct_half #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         start,
  input  logic         wrap,
  input  logic         inc,
  output logic [W-1:0] count_o,
  output logic         eq_o
);
  logic [W-1:0] data_q;
  logic [W-1:0] latch_q, latch_d;
  logic [W-1:0] cnt_q, cnt_d;
  logic         latch_en;

  // data register: no defined reset value, written only by software
  always_ff @(posedge clk) begin
    if (wr_en) data_q <= wr_data;
  end

  always_comb begin
    latch_en = start | wrap;
    latch_d  = latch_en ? data_q : latch_q;
    if (start || wrap) cnt_d = '0;
    else if (inc)      cnt_d = cnt_q + W'(1);
    else               cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q <= '0;
      cnt_q   <= '0;
    end else begin
      latch_q <= latch_d;
      cnt_q   <= cnt_d;
    end
  end

  assign count_o = cnt_q;
  assign eq_o    = (cnt_q == latch_q);
endmodule

// File: rtl/cascade_timer.sv
module cascade_timer
  import cascade_timer_pkg::*;
#(
  parameter int HALF_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [HALF_W-1:0] wr_data,
  input  logic              rd_sel,
  output logic [HALF_W-1:0] rd_data,
  input  logic [1:0]        run,
  input  logic              cascade,
  input  logic [1:0]        src_sel,
  input  logic              tick_i,
  input  logic [1:0]        evt_i,
  input  logic [1:0]        flag_clr,
  output logic [1:0]        flag_o
);
  localparam int NCH = 2;

  logic [NCH-1:0]    evt_rise;
  logic [NCH-1:0]    run_q, run_d;
  logic [NCH-1:0]    flag_q, flag_d;
  logic [NCH-1:0]    start_ch, adv_ch;
  logic [NCH-1:0]    start_h, wrap_h, inc_h, set_flag, eq_h, wr_h;
  logic              match_16, ones_lo;
  logic [HALF_W-1:0] cnt_w [NCH];
  logic [HALF_W-1:0] cnt_lo, cnt_hi;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    ct_event_sync #(.STAGES(SYNC_STAGES)) sync_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .evt_i  (evt_i[g]),
      .rise_o (evt_rise[g])
    );

    assign wr_h[g] = wr_en & (wr_sel == 1'(g));

    ct_half #(.W(HALF_W)) half_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_h[g]),
      .wr_data (wr_data),
      .start   (start_h[g]),
      .wrap    (wrap_h[g]),
      .inc     (inc_h[g]),
      .count_o (cnt_w[g]),
      .eq_o    (eq_h[g])
    );
  end

  assign cnt_lo  = cnt_w[0];
  assign cnt_hi  = cnt_w[1];
  assign ones_lo = &cnt_lo;

  // next-state logic for control, step routing and flags
  always_comb begin
    for (int i = 0; i < NCH; i++) begin
      start_ch[i] = run[i] & ~run_q[i];
      adv_ch[i]   = run[i] & ~start_ch[i] &
                    ((src_e'(src_sel[i]) == SRC_EVENT) ? evt_rise[i] : tick_i);
    end
    match_16 = eq_h[0] & eq_h[1];
    if (cascade) begin
      start_h  = {NCH{start_ch[0]}};
      wrap_h   = {NCH{adv_ch[0] & match_16}};
      inc_h[0] = adv_ch[0] & ~match_16;
      inc_h[1] = adv_ch[0] & ~match_16 & ones_lo;
      set_flag = {1'b0, adv_ch[0] & match_16};
    end else begin
      start_h  = start_ch;
      wrap_h   = adv_ch & eq_h;
      inc_h    = adv_ch & ~eq_h;
      set_flag = adv_ch & eq_h;
    end
    flag_d = set_flag | (flag_q & ~flag_clr);
    run_d  = run;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= '0;
      flag_q <= '0;
    end else begin
      run_q  <= run_d;
      flag_q <= flag_d;
    end
  end

  assign rd_data = rd_sel ? cnt_hi : cnt_lo;
  assign flag_o  = flag_q;
endmodule

// File: rtl/ct_checker.sv
module ct_checker #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic [1:0]   run,
  input logic         cascade,
  input logic [1:0]   flag_clr,
  input logic [1:0]   flag,
  input logic [1:0]   set_flag,
  input logic [W-1:0] cnt_lo,
  input logic [W-1:0] cnt_hi,
  input logic         start_lo,
  input logic         wrap_lo
);
  a_r3_stopped_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !run[0] |=> $stable(cnt_lo));

  a_r2_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    start_lo |=> (cnt_lo == '0));

  a_r4_wrap_zero_flag: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_lo |=> (cnt_lo == '0) && flag[0]);

  a_r7_clear_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr[1] && !set_flag[1]) |=> !flag[1]);

  a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (flag[0] && !flag_clr[0]) |=> flag[0]);

  a_r8_upper_follows_run0: assert property (@(posedge clk) disable iff (!rst_n)
    (cascade && !run[0]) |=> $stable(cnt_hi));

  a_r8_no_upper_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (cascade && !flag[1]) |=> !flag[1]);
endmodule

bind cascade_timer ct_checker #(.W(HALF_W)) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .run      (run),
  .cascade  (cascade),
  .flag_clr (flag_clr),
  .flag     (flag_o),
  .set_flag (set_flag),
  .cnt_lo   (cnt_lo),
  .cnt_hi   (cnt_hi),
  .start_lo (start_h[0]),
  .wrap_lo  (wrap_h[0])
);

// File: tb/cascade_timer_tb_top.sv
module cascade_timer_tb_top;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         wr_en = 1'b0, wr_sel = 1'b0, rd_sel = 1'b0;
  logic [W-1:0] wr_data = '0;
  logic [W-1:0] rd_data;
  logic [1:0]   run = '0, src_sel = '0, evt_i = '0, flag_clr = '0, flag_o;
  logic         cascade = 1'b0, tick_i = 1'b0;

  int n_tests = 0;
  int n_fail  = 0;

  always #10 clk = ~clk;

  cascade_timer dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data), .run(run),
    .cascade(cascade), .src_sel(src_sel), .tick_i(tick_i), .evt_i(evt_i),
    .flag_clr(flag_clr), .flag_o(flag_o)
  );

  // {value[32:25], ticks[24:9], expected count[8:1], expected flag[0]}
  localparam logic [32:0] VEC [8] = '{
    {8'd5,   16'd3,   8'd3,   1'b0},
    {8'd5,   16'd6,   8'd0,   1'b1},
    {8'd5,   16'd7,   8'd1,   1'b1},
    {8'd0,   16'd4,   8'd0,   1'b1},
    {8'd255, 16'd255, 8'd255, 1'b0},
    {8'd255, 16'd256, 8'd0,   1'b1},
    {8'd10,  16'd25,  8'd3,   1'b1},
    {8'd1,   16'd3,   8'd1,   1'b1}
  };

  task automatic chk(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chk_cnt(input string req, input logic sel, input int exp);
    rd_sel = sel;
    #1;
    chk(req, int'(rd_data), exp);
  endtask

  task automatic wr(input logic sel, input logic [W-1:0] v);
    @(negedge clk); wr_en = 1'b1; wr_sel = sel; wr_data = v;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic set_run(input int ch, input logic v);
    @(negedge clk); run[ch] = v;
  endtask

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); tick_i = 1'b1;
    end
    @(negedge clk); tick_i = 1'b0;
  endtask

  task automatic clr_flags();
    @(negedge clk); flag_clr = 2'b11;
    @(negedge clk); flag_clr = 2'b00;
  endtask

  task automatic pulse_evt(input int ch);
    @(negedge clk); evt_i[ch] = 1'b1;
    repeat (3) @(negedge clk);
    evt_i[ch] = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state
    chk_cnt("R1 reset lower count", 1'b0, 0);
    chk_cnt("R1 reset upper count", 1'b1, 0);
    chk("R7 reset flags", int'(flag_o), 0);

    // table of interval periods on the lower half (R4, R2)
    for (int i = 0; i < 8; i++) begin
      set_run(0, 1'b0);
      clr_flags();
      wr(1'b0, VEC[i][32:25]);
      set_run(0, 1'b1);
      ticks(int'(VEC[i][24:9]));
      chk_cnt($sformatf("R4 vector %0d count", i), 1'b0, int'(VEC[i][8:1]));
      chk($sformatf("R4 vector %0d flag", i), int'(flag_o[0]), int'(VEC[i][0]));
    end

    // R5: a write during a run waits for the next match
    set_run(0, 1'b0);
    clr_flags();
    wr(1'b0, 8'd4);
    set_run(0, 1'b1);
    ticks(2);
    wr(1'b0, 8'd9);
    ticks(2);
    chk_cnt("R5 old period still counting", 1'b0, 4);
    ticks(1);
    chk_cnt("R5 wrap at old value", 1'b0, 0);
    chk("R5 flag at old value", int'(flag_o[0]), 1);
    clr_flags();
    chk("R7 flag cleared", int'(flag_o[0]), 0);
    ticks(9);
    chk_cnt("R5 new value in effect", 1'b0, 9);
    chk("R5 no early flag", int'(flag_o[0]), 0);

    // R3 and R1: stopped count holds, write is not readable
    set_run(0, 1'b0);
    wr(1'b0, 8'h77);
    ticks(3);
    chk_cnt("R1 R3 read shows held count", 1'b0, 9);

    // R2: restart clears and loads 0x77
    set_run(0, 1'b1);
    @(negedge clk);
    chk_cnt("R2 start clears count", 1'b0, 0);
    ticks(119);
    chk_cnt("R2 latch loaded at start", 1'b0, 119);
    chk("R2 no flag before match", int'(flag_o[0]), 0);
    ticks(1);
    chk("R2 match at loaded value", int'(flag_o[0]), 1);
    set_run(0, 1'b0);

    // R6: event mode on the upper half
    clr_flags();
    src_sel[1] = 1'b1;
    wr(1'b1, 8'd2);
    set_run(1, 1'b1);
    ticks(10);
    chk_cnt("R6 tick ignored in event mode", 1'b1, 0);
    pulse_evt(1);
    pulse_evt(1);
    chk_cnt("R6 two events counted", 1'b1, 2);
    chk("R6 no flag yet", int'(flag_o[1]), 0);
    pulse_evt(1);
    chk_cnt("R6 wrap on third event", 1'b1, 0);
    chk("R6 flag on match", int'(flag_o[1]), 1);
    repeat (5) @(negedge clk);
    chk("R7 flag sticky", int'(flag_o[1]), 1);
    @(negedge clk); flag_clr[1] = 1'b1;
    @(negedge clk); flag_clr[1] = 1'b0;
    chk("R7 flag cleared by strobe", int'(flag_o[1]), 0);

    // R9: halves independent
    wr(1'b0, 8'd50);
    set_run(0, 1'b1);
    ticks(5);
    chk_cnt("R9 lower counts ticks", 1'b0, 5);
    chk_cnt("R9 upper unaffected", 1'b1, 0);
    pulse_evt(1);
    chk_cnt("R9 upper counts its event", 1'b1, 1);
    chk_cnt("R9 lower unaffected", 1'b0, 5);

    // R8: cascaded 16-bit compare of 0x012C
    set_run(0, 1'b0);
    set_run(1, 1'b0);
    src_sel = 2'b00;
    cascade = 1'b1;
    wr(1'b0, 8'h2C);
    wr(1'b1, 8'h01);
    clr_flags();
    set_run(0, 1'b1);
    ticks(256);
    chk_cnt("R8 carry into upper", 1'b1, 1);
    chk_cnt("R8 lower after carry", 1'b0, 0);
    ticks(44);
    chk_cnt("R8 lower at compare", 1'b0, 8'h2C);
    chk("R8 no flag before 16-bit match", int'(flag_o), 0);
    ticks(1);
    chk_cnt("R8 lower wraps", 1'b0, 0);
    chk_cnt("R8 upper wraps", 1'b1, 0);
    chk("R8 lower flag only", int'(flag_o), 1);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule